// File: doc/BRIEF.md
# Slave Audio Clock Ratio and Speed Detector

This block sits behind the clock pins of an audio converter that runs as a clock slave. The master clock, the bit clock and the frame (left/right) clock all arrive from outside and are only sampled, never driven. A fast free-running system clock oversamples all three. The block then measures each frame, meaning the interval between two rising edges of the frame clock. It counts master-clock edges, bit-clock edges and system-clock cycles over that interval, and it counts the master-clock edges seen while the frame clock is high.

From these counts the block names one of six master-clock ratios. It also decides whether the stream is single or double speed. Two ratios (256 and 384) occur in both speed classes, so for those the system-clock length of the frame decides the speed. A frame is only accepted when the frame clock's high share and the bit-clock count per frame are legal for the detected ratio.

A lock indicator gives downstream filter and serializer logic a stable classification. It is set after a run of identical accepted frames and cleared by repeated disagreement. A frame with an illegal bit-clock count clears it at once and raises an error flag.

Top module: `aud_slave_clkdet`

## Requirements
- R1: After reset, `locked`, `dbl_speed` and `sclk_err` are 0 and `ratio_id` is 7.
- R2: The master-clock edges between consecutive frame-clock rising edges are matched to a ratio within ±TOL (default 2) and coded on `ratio_id` as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768.
- R3: Ratios 128 and 192 are always double speed (`dbl_speed`=1), and ratios 512 and 768 are always single speed.
- R4: For ratios 256 and 384, a frame shorter than REF_DS_LIMIT system-clock cycles (default 1786) is double speed; otherwise it is single speed.
- R5: `locked` rises at the end of the third consecutive accepted frame with the same ratio and speed. The frame cut short by reset is never evaluated. While unlocked, `ratio_id` reads 7 and `dbl_speed` reads 0.
- R6: While locked, one frame that is not accepted or that differs in class leaves all outputs unchanged. A second such frame in a row clears `locked`, and three fresh matching frames are then needed to lock again.
- R7: The bit-clock count must be 64, or 48 for ratios 192, 384 and 768. Another count on a frame with a valid ratio and duty sets `sclk_err` and clears `locked` at that frame. `sclk_err` returns to 0 at the next frame that does not show this fault.
- R8: A frame is valid only if the master-clock count while the frame clock is high lies between 40% and 60% of the frame's count, both limits included. A frame outside these limits counts as a mismatch.
- R9: A frame whose master-clock count matches no ratio within ±TOL counts as a mismatch and never sets `sclk_err`.
- R10: All outputs change only in the clock cycle that follows a detected frame-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system and reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_in | input | 1 | External master clock (asynchronous) |
| sclk_in | input | 1 | External bit clock (asynchronous) |
| lrck_in | input | 1 | External frame clock (asynchronous) |
| locked | output | 1 | Classification is stable |
| dbl_speed | output | 1 | Locked stream is double speed |
| ratio_id | output | 3 | Locked master-clock ratio code, 7 when unlocked |
| sclk_err | output | 1 | Last frame had an illegal bit-clock count |

## Verification
In every frame a master-clock edge, a bit-clock edge and a frame-clock rising edge reach the synchronizer outputs in the same system-clock cycle. In that one cycle the block must close the old frame's counts and open the new frame with the coincident edge. The bench builds all three clocks from one master-clock loop, so this coincidence is provoked on every frame boundary. It is judged by the exact counts needed for ratio, bit-clock and duty decisions: the 258/259 tolerance edge and the 103-of-256 duty limit fail if the boundary edge is counted twice or dropped. A second overlap, where a lock drop and a bit-clock error land on the same frame, is provoked by feeding a 32-edge frame straight after a locked run.

// File: rtl/sdet_pkg.sv
package sdet_pkg;

  localparam int unsigned NUM_RATIOS = 6;
  localparam logic [2:0]  RID_NONE   = 3'd7;

  typedef struct packed {
    logic       dbl;
    logic [2:0] rid;
  } sdet_cls_t;

  // Ratio codes: even codes are 128 << (code/2), odd codes are 1.5x the even one below.
  function automatic int unsigned ratio_value(input logic [2:0] rid);
    int unsigned base;
    base = 32'd128 << rid[2:1];
    return rid[0] ? base + (base >> 1) : base;
  endfunction

  function automatic logic [2:0] match_ratio(input int unsigned cnt, input int unsigned tol);
    logic [2:0] found;
    found = RID_NONE;
    for (int k = NUM_RATIOS - 1; k >= 0; k--) begin
      int unsigned rv;
      rv = ratio_value(3'(k));
      if ((cnt + tol >= rv) && (cnt <= rv + tol)) found = 3'(k);
    end
    return found;
  endfunction

  // Odd codes (192, 384, 768) also accept the short bit-clock frame.
  function automatic logic sclk_legal(input logic [2:0] rid, input int unsigned n,
                                      input int unsigned n_full, input int unsigned n_short);
    return (n == n_full) || (rid[0] && (n == n_short));
  endfunction

  function automatic logic duty_legal(input int unsigned hi, input int unsigned tot);
    return (hi * 5 >= tot * 2) && (hi * 5 <= tot * 3);
  endfunction

endpackage

// File: rtl/sdet_sync.sv
module sdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/sdet_frame_meter.sv
module sdet_frame_meter #(
  parameter int CNT_W = 12,
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_rise,
  input  logic             sclk_rise,
  input  logic             lrck_lvl,
  input  logic             lrck_rise,
  output logic             frame_end,
  output logic [CNT_W-1:0] mclk_cnt,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] sclk_cnt,
  output logic [REF_W-1:0] ref_cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [REF_W-1:0] REF_TOP = '1;

  logic             armed;
  logic [CNT_W-1:0] mclk_c, hi_c, sclk_c;
  logic [REF_W-1:0] ref_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      mclk_c <= '0;
      hi_c   <= '0;
      sclk_c <= '0;
      ref_c  <= '0;
    end else if (lrck_rise) begin
      // The edge that coincides with the boundary belongs to the new frame.
      armed  <= 1'b1;
      mclk_c <= CNT_W'(mclk_rise);
      hi_c   <= CNT_W'(mclk_rise);
      sclk_c <= CNT_W'(sclk_rise);
      ref_c  <= REF_W'(1);
    end else begin
      if (mclk_rise && mclk_c != CNT_TOP) mclk_c <= mclk_c + 1'b1;
      if (mclk_rise && lrck_lvl && hi_c != CNT_TOP) hi_c <= hi_c + 1'b1;
      if (sclk_rise && sclk_c != CNT_TOP) sclk_c <= sclk_c + 1'b1;
      if (ref_c != REF_TOP) ref_c <= ref_c + 1'b1;
    end
  end

  assign frame_end = lrck_rise & armed;
  assign mclk_cnt  = mclk_c;
  assign hi_cnt    = hi_c;
  assign sclk_cnt  = sclk_c;
  assign ref_cnt   = ref_c;
endmodule

// File: rtl/sdet_classify.sv
module sdet_classify
  import sdet_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int REF_W        = 16,
  parameter int TOL          = 2,
  parameter int REF_DS_LIMIT = 1786,
  parameter int SCLK_FULL    = 64,
  parameter int SCLK_SHORT   = 48
) (
  input  logic [CNT_W-1:0] mclk_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] sclk_cnt,
  input  logic [REF_W-1:0] ref_cnt,
  output logic             frame_valid,
  output logic             sclk_bad,
  output sdet_cls_t        cls
);
  logic [2:0] rid;
  logic       fast;

  always_comb begin
    rid         = match_ratio(int'(mclk_cnt), TOL);
    fast        = int'(ref_cnt) < REF_DS_LIMIT;
    frame_valid = (rid != RID_NONE) && duty_legal(int'(hi_cnt), int'(mclk_cnt));
    sclk_bad    = frame_valid && !sclk_legal(rid, int'(sclk_cnt), SCLK_FULL, SCLK_SHORT);
    cls.rid     = rid;
    unique case (rid)
      3'd0, 3'd1: cls.dbl = 1'b1;
      3'd2, 3'd3: cls.dbl = fast;
      default:    cls.dbl = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdet_lock.sv
module sdet_lock
  import sdet_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int DROP_FRAMES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_end,
  input  logic      frame_valid,
  input  logic      sclk_bad,
  input  sdet_cls_t cls,
  output logic      locked,
  output sdet_cls_t held,
  output logic      sclk_err
);
  localparam int RUN_W  = $clog2(LOCK_FRAMES + 1);
  localparam int MISS_W = $clog2(DROP_FRAMES + 1);

  logic [RUN_W-1:0]  run;
  logic [MISS_W-1:0] miss;
  sdet_cls_t         cand;
  logic              good;

  assign good = frame_valid && !sclk_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      sclk_err <= 1'b0;
      run      <= '0;
      miss     <= '0;
      cand     <= '0;
      held     <= '0;
    end else if (frame_end) begin
      sclk_err <= sclk_bad;
      if (sclk_bad) begin
        locked <= 1'b0;
        run    <= '0;
        miss   <= '0;
      end else if (locked) begin
        if (good && cls == held) begin
          miss <= '0;
        end else if (miss == MISS_W'(DROP_FRAMES - 1)) begin
          locked <= 1'b0;
          run    <= '0;
          miss   <= '0;
        end else begin
          miss <= miss + 1'b1;
        end
      end else if (good) begin
        if (run != '0 && cls == cand) begin
          if (run == RUN_W'(LOCK_FRAMES - 1)) begin
            locked <= 1'b1;
            held   <= cand;
            run    <= '0;
            miss   <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          cand <= cls;
          run  <= RUN_W'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/aud_slave_clkdet.sv
module aud_slave_clkdet
  import sdet_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 12,
  parameter int REF_W        = 16,
  parameter int TOL          = 2,
  parameter int REF_DS_LIMIT = 1786,
  parameter int SCLK_FULL    = 64,
  parameter int SCLK_SHORT   = 48,
  parameter int LOCK_FRAMES  = 3,
  parameter int DROP_FRAMES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_in,
  input  logic       sclk_in,
  input  logic       lrck_in,
  output logic       locked,
  output logic       dbl_speed,
  output logic [2:0] ratio_id,
  output logic       sclk_err
);
  localparam int NUM_CLK_IN = 3;

  logic [NUM_CLK_IN-1:0] raw_in, sync_lvl, sync_rise;
  assign raw_in = {lrck_in, sclk_in, mclk_in};

  for (genvar g = 0; g < NUM_CLK_IN; g++) begin : g_sync
    sdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[g]),
      .lvl  (sync_lvl[g]),
      .rise (sync_rise[g])
    );
  end

  logic             frame_end;
  logic [CNT_W-1:0] mclk_cnt, hi_cnt, sclk_cnt;
  logic [REF_W-1:0] ref_cnt;

  sdet_frame_meter #(.CNT_W(CNT_W), .REF_W(REF_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclk_rise(sync_rise[0]),
    .sclk_rise(sync_rise[1]),
    .lrck_lvl (sync_lvl[2]),
    .lrck_rise(sync_rise[2]),
    .frame_end(frame_end),
    .mclk_cnt (mclk_cnt),
    .hi_cnt   (hi_cnt),
    .sclk_cnt (sclk_cnt),
    .ref_cnt  (ref_cnt)
  );

  logic      frame_valid, sclk_bad;
  sdet_cls_t frame_cls, held_cls;

  sdet_classify #(
    .CNT_W(CNT_W), .REF_W(REF_W), .TOL(TOL), .REF_DS_LIMIT(REF_DS_LIMIT),
    .SCLK_FULL(SCLK_FULL), .SCLK_SHORT(SCLK_SHORT)
  ) u_classify (
    .mclk_cnt   (mclk_cnt),
    .hi_cnt     (hi_cnt),
    .sclk_cnt   (sclk_cnt),
    .ref_cnt    (ref_cnt),
    .frame_valid(frame_valid),
    .sclk_bad   (sclk_bad),
    .cls        (frame_cls)
  );

  sdet_lock #(.LOCK_FRAMES(LOCK_FRAMES), .DROP_FRAMES(DROP_FRAMES)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .frame_valid(frame_valid),
    .sclk_bad   (sclk_bad),
    .cls        (frame_cls),
    .locked     (locked),
    .held       (held_cls),
    .sclk_err   (sclk_err)
  );

  assign dbl_speed = locked & held_cls.dbl;
  assign ratio_id  = locked ? held_cls.rid : RID_NONE;
endmodule

// File: rtl/sdet_checker.sv
module sdet_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_end,
  input logic       locked,
  input logic       dbl_speed,
  input logic [2:0] ratio_id,
  input logic       sclk_err
);
  AST_UNLOCKED_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (ratio_id == 3'd7 && !dbl_speed)); // R5

  AST_LOCK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_end)); // R5

  AST_ERR_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_err |-> !locked); // R7

  AST_QUIET_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({locked, dbl_speed, ratio_id, sclk_err})); // R10

  AST_SLOW_RATIOS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ratio_id[2]) |-> !dbl_speed); // R3

  AST_FAST_RATIOS_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ratio_id < 3'd2) |-> dbl_speed); // R3

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_id != 3'd6); // R2
endmodule

bind aud_slave_clkdet sdet_checker u_sdet_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_end(frame_end),
  .locked   (locked),
  .dbl_speed(dbl_speed),
  .ratio_id (ratio_id),
  .sclk_err (sclk_err)
);

// File: tb/aud_slave_clkdet_bench.sv
module aud_slave_clkdet_bench;
  localparam int LIMIT = 1786;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_in = 1'b0, sclk_in = 1'b0, lrck_in = 1'b0;
  logic locked, dbl_speed, sclk_err;
  logic [2:0] ratio_id;

  always #4 clk = ~clk;

  aud_slave_clkdet u_aud_slave_clkdet (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .locked(locked), .dbl_speed(dbl_speed), .ratio_id(ratio_id), .sclk_err(sclk_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  // Bench model state
  bit         m_locked = 0, m_err = 0;
  bit         m_hdbl = 0;
  int         m_hrid = 7;
  int         m_run = 0, m_miss = 0, m_cdbl = 0, m_crid = 7;
  bit         armed = 0;
  int         p_r, p_n, p_hi, p_mper;

  function automatic logic [5:0] outs_now();
    return {locked, dbl_speed, ratio_id, sclk_err};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got {lock,dbl,rid,err}=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int code_of(input int r);
    int table_v[6] = '{128, 192, 256, 384, 512, 768};
    for (int i = 0; i < 6; i++)
      if (r >= table_v[i] - 2 && r <= table_v[i] + 2) return i;
    return 7;
  endfunction

  // Apply the requirement rules to one completed frame and queue the expected outputs.
  task automatic judge(input string tag);
    int  rid;
    bit  ok_frame, bad_bits, is_dbl, same;
    rid      = code_of(p_r);
    ok_frame = (rid != 7) && (p_hi * 5 >= p_r * 2) && (p_hi * 5 <= p_r * 3);
    bad_bits = ok_frame && !(p_n == 64 || (p_n == 48 && (rid % 2 == 1)));
    is_dbl   = (rid < 2) || (rid < 4 && p_r * p_mper < LIMIT);
    m_err    = bad_bits;
    if (bad_bits) begin
      m_locked = 0; m_run = 0; m_miss = 0;
    end else if (m_locked) begin
      same = ok_frame && rid == m_hrid && is_dbl == m_hdbl;
      if (same) m_miss = 0;
      else begin
        m_miss++;
        if (m_miss >= 2) begin m_locked = 0; m_run = 0; m_miss = 0; end
      end
    end else if (ok_frame) begin
      if (m_run > 0 && rid == m_crid && int'(is_dbl) == m_cdbl) m_run++;
      else begin m_run = 1; m_crid = rid; m_cdbl = is_dbl; end
      if (m_run == 3) begin
        m_locked = 1; m_hrid = rid; m_hdbl = is_dbl; m_run = 0; m_miss = 0;
      end
    end else m_run = 0;
    exp_q.push_back({m_locked, m_locked & m_hdbl, m_locked ? 3'(m_hrid) : 3'd7, m_err});
    tag_q.push_back(tag);
  endtask

  // Driver: frames of r master clocks, n bit clocks, hi master clocks with frame clock high.
  task automatic frames(input int r, input int n, input int hi, input int mper,
                        input int count, input string tag);
    for (int f = 0; f < count; f++) begin
      for (int m = 0; m < r; m++) begin
        mclk_in = 1'b1;
        lrck_in = (m < hi);
        sclk_in = (((m * 2 * n) / r) % 2) == 0;
        if (m == 0) begin
          if (armed) judge(tag);
          armed = 1; p_r = r; p_n = n; p_hi = hi; p_mper = mper;
        end
        repeat (mper / 2) @(negedge clk);
        mclk_in = 1'b0;
        repeat (mper / 2) @(negedge clk);
      end
    end
  endtask

  // Monitor: compares right after each boundary, then again mid-frame.
  initial begin
    forever begin
      logic [5:0] e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q[0];
      t = tag_q[0];
      repeat (8) @(negedge clk);
      check(t, outs_now(), e);
      repeat (100) @(negedge clk);
      check("R10 held mid-frame", outs_now(), e);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 reset state", outs_now(), 6'b0_0_111_0);

    frames(256, 64, 128, 4, 4, "R5 lock 256 double");
    frames(256, 64, 128, 8, 7, "R4 256 slow frames single");
    frames(384, 48, 192, 4, 6, "R2 384 short bit clock");
    frames(768, 48, 384, 4, 6, "R3 768 single");
    frames(128, 64, 64, 4, 6, "R3 128 double");
    frames(512, 64, 256, 4, 6, "R2 512");
    frames(192, 64, 96, 4, 6, "R2 192");
    frames(384, 64, 192, 8, 6, "R4 384 slow single");
    frames(256, 64, 128, 4, 5, "R5 relock 256");
    frames(256, 64, 77, 4, 1, "R8 one bad duty");
    frames(256, 64, 128, 4, 3, "R6 single miss keeps lock");
    frames(256, 64, 77, 4, 2, "R8 two bad duty");
    frames(256, 64, 128, 4, 4, "R6 drop then relock");
    frames(256, 64, 103, 4, 2, "R8 duty 40pct limit");
    frames(258, 64, 129, 4, 3, "R2 tolerance edge");
    frames(259, 64, 130, 4, 3, "R9 out of tolerance");
    frames(254, 64, 127, 4, 4, "R2 low tolerance edge");
    frames(256, 32, 128, 4, 2, "R7 bad bit count");
    frames(256, 64, 128, 4, 2, "R7 error clears");
    frames(512, 48, 256, 4, 2, "R7 short count on 512");
    frames(512, 64, 256, 4, 1, "R7 recover");

    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule